// File: doc/BRIEF.md
# Paper-Tape Absolute Binary Loader

This block takes a stream of paper-tape frames, one byte per accepted valid/ready transfer, and turns it into word writes on a plain memory port. The tape holds one or more absolute-binary records with runs of blank (all-zero) frames between them. Each record gives a word count, a start address and the data words. A 16-bit checksum closes each record. The block writes every data word to the next address and checks the checksum. It then waits for the next record or for the blank trailer that ends the tape.

A separate end-of-stream input tells the loader that the tape has run out. The result is reported on three sticky status outputs: a normal finish, a checksum fault or a framing fault. A one-cycle start pulse clears the status and rearms the parser. The parameter `MEM_WORDS` sets the size of the memory behind the write port. Words aimed above that size are dropped, but they are still counted in the address and in the checksum.

Top module: `tape_loader`

## Requirements
- R1: After reset, and in the cycle after a start pulse, all three status outputs are 0, `in_ready` is 1, and the parser is skipping leader.
- R2: Before the first record, any number of zero frames is accepted without any effect.
- R3: In each record, the first nonzero frame is the word count (1 to 255). The next frame is discarded, whatever its value. The two frames after that form the 16-bit origin, high byte first.
- R4: Each data word is two frames, high byte first. Word k is written to address origin+k. `mem_we` is high for exactly the cycle in which the low byte is accepted, with `mem_wdata` equal to the word.
- R5: After the data comes a checksum word, high byte first. It must equal the 16-bit sum of the origin and all data words; the count is not included. If it does not match, `csum_err` is raised and loading stops.
- R6: A word whose address is not below `MEM_WORDS` causes no write. The address still advances and the word still counts in the checksum.
- R7: If end of stream arrives while the parser is waiting for a count frame, `done` is raised. If it arrives anywhere inside a record, `fmt_err` is raised.
- R8: After a record passes its checksum, the eleventh consecutive zero frame raises `done`. A nonzero frame that comes earlier starts a new record.
- R9: Once loading has finished, the status outputs hold their values and `in_ready` stays 0 until a start pulse. Frames offered in that time are not accepted and cause no writes.
- R10: The address counter wraps from 0xFFFF to 0x0000.
- R11: At most one of `done`, `csum_err` and `fmt_err` is set at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: clear status, restart parsing |
| in_valid | input | 1 | Frame on `in_byte` is valid |
| in_ready | output | 1 | Loader accepts a frame this cycle |
| in_byte | input | 8 | Tape frame |
| in_eos | input | 1 | End of the tape stream |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | clog2(MEM_WORDS) | Word address of the write |
| mem_wdata | output | 16 | Word to write |
| done | output | 1 | Load finished normally (sticky) |
| csum_err | output | 1 | Checksum mismatch (sticky) |
| fmt_err | output | 1 | Stream ended inside a record (sticky) |

## Verification
The write strobe is combinational. It appears in the same cycle as the accepted low byte, so the bench samples it one nanosecond after driving that byte, before the clock edge. The status flags and `in_ready` change at the edge that accepts the deciding frame or the end-of-stream marker. The bench therefore reads them at the falling edge that follows. A sweep over origins that cross the end of the small memory, together with a range of word counts, compares every captured write and the write count with values computed from the record.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    ST_LEADER,
    ST_GAP,
    ST_SKIP,
    ST_ORG_HI,
    ST_ORG_LO,
    ST_DAT_HI,
    ST_DAT_LO,
    ST_SUM_HI,
    ST_SUM_LO,
    ST_FIN
  } tl_state_e;

  // True while waiting for a count frame (end of stream is clean here).
  function automatic logic between_records(tl_state_e s);
    return (s == ST_LEADER) || (s == ST_GAP);
  endfunction
endpackage

// File: rtl/tl_rst_sync.sv
module tl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tl_seq.sv
module tl_seq
  import tl_pkg::*;
#(
  parameter int ZERO_LIMIT = 11,
  localparam int ZW = $clog2(ZERO_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              take,
  input  logic              eos,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              sum_match,
  output tl_state_e         state,
  output logic              ev_done,
  output logic              ev_fmt,
  output logic              ev_csum
);
  localparam logic [ZW-1:0] ZC_LAST = ZW'(ZERO_LIMIT - 1);

  tl_state_e         st_q, st_d;
  logic [ZW-1:0]     zc_q, zc_d;
  logic [BYTE_W-1:0] rem_q, rem_d;
  logic              byte_zero;

  assign byte_zero = (byte_in == '0);
  assign state     = st_q;

  always_comb begin
    st_d    = st_q;
    zc_d    = zc_q;
    rem_d   = rem_q;
    ev_done = 1'b0;
    ev_fmt  = 1'b0;
    ev_csum = 1'b0;
    if (start) begin
      st_d  = ST_LEADER;
      zc_d  = '0;
      rem_d = '0;
    end else if (eos && (st_q != ST_FIN)) begin
      st_d = ST_FIN;
      if (between_records(st_q)) ev_done = 1'b1;
      else                       ev_fmt  = 1'b1;
    end else if (take) begin
      case (st_q)
        ST_LEADER: begin
          if (!byte_zero) begin
            rem_d = byte_in;
            st_d  = ST_SKIP;
          end
        end
        ST_GAP: begin
          if (!byte_zero) begin
            rem_d = byte_in;
            st_d  = ST_SKIP;
          end else if (zc_q == ZC_LAST) begin
            st_d    = ST_FIN;
            ev_done = 1'b1;
          end else begin
            zc_d = zc_q + 1'b1;
          end
        end
        ST_SKIP:   st_d = ST_ORG_HI;
        ST_ORG_HI: st_d = ST_ORG_LO;
        ST_ORG_LO: st_d = ST_DAT_HI;
        ST_DAT_HI: st_d = ST_DAT_LO;
        ST_DAT_LO: begin
          rem_d = rem_q - 1'b1;
          st_d  = (rem_q == 8'd1) ? ST_SUM_HI : ST_DAT_HI;
        end
        ST_SUM_HI: st_d = ST_SUM_LO;
        ST_SUM_LO: begin
          if (sum_match) begin
            st_d = ST_GAP;
            zc_d = '0;
          end else begin
            st_d    = ST_FIN;
            ev_csum = 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_LEADER;
      zc_q  <= '0;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      zc_q  <= zc_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/tl_datapath.sv
module tl_datapath
  import tl_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int AW = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tl_state_e         state,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              sum_match,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  localparam logic [WORD_W:0] LIMIT = (WORD_W+1)'(MEM_WORDS);

  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [WORD_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] sum_q, sum_d;
  logic [WORD_W-1:0] word;
  logic              hi_en, org_en, dat_en, in_range;

  assign word     = {hi_q, byte_in};
  assign hi_en    = take && ((state == ST_ORG_HI) || (state == ST_DAT_HI) ||
                             (state == ST_SUM_HI));
  assign org_en   = take && (state == ST_ORG_LO);
  assign dat_en   = take && (state == ST_DAT_LO);
  assign in_range = ({1'b0, addr_q} < LIMIT);

  always_comb begin
    hi_d   = hi_q;
    addr_d = addr_q;
    sum_d  = sum_q;
    if (hi_en) hi_d = byte_in;
    if (org_en) begin
      addr_d = word;
      sum_d  = word;
    end else if (dat_en) begin
      addr_d = addr_q + 16'd1;
      sum_d  = sum_q + word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      addr_q <= '0;
      sum_q  <= '0;
    end else begin
      hi_q   <= hi_d;
      addr_q <= addr_d;
      sum_q  <= sum_d;
    end
  end

  assign sum_match = (word == sum_q);
  assign mem_we    = dat_en && in_range;
  assign mem_addr  = addr_q[AW-1:0];
  assign mem_wdata = word;
endmodule

// File: rtl/tl_status.sv
module tl_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ev_done,
  input  logic ev_fmt,
  input  logic ev_csum,
  output logic done,
  output logic fmt_err,
  output logic csum_err
);
  logic done_d, fmt_d, csum_d;

  always_comb begin
    done_d = done;
    fmt_d  = fmt_err;
    csum_d = csum_err;
    if (start) begin
      done_d = 1'b0;
      fmt_d  = 1'b0;
      csum_d = 1'b0;
    end else begin
      if (ev_done) done_d = 1'b1;
      if (ev_fmt)  fmt_d  = 1'b1;
      if (ev_csum) csum_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      fmt_err  <= 1'b0;
      csum_err <= 1'b0;
    end else begin
      done     <= done_d;
      fmt_err  <= fmt_d;
      csum_err <= csum_d;
    end
  end
endmodule

// File: rtl/tape_loader.sv
module tape_loader
  import tl_pkg::*;
#(
  parameter int MEM_WORDS  = 64,
  parameter int ZERO_LIMIT = 11,
  localparam int AW = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic              in_eos,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              done,
  output logic              csum_err,
  output logic              fmt_err
);
  logic      rst_n_s;
  tl_state_e state;
  logic      take, sum_match, ev_done, ev_fmt, ev_csum;

  tl_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  assign in_ready = (state != ST_FIN);
  assign take     = in_valid && in_ready;

  tl_seq #(.ZERO_LIMIT(ZERO_LIMIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .take      (take),
    .eos       (in_eos),
    .byte_in   (in_byte),
    .sum_match (sum_match),
    .state     (state),
    .ev_done   (ev_done),
    .ev_fmt    (ev_fmt),
    .ev_csum   (ev_csum)
  );

  tl_datapath #(.MEM_WORDS(MEM_WORDS)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .state     (state),
    .take      (take),
    .byte_in   (in_byte),
    .sum_match (sum_match),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  tl_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .ev_done  (ev_done),
    .ev_fmt   (ev_fmt),
    .ev_csum  (ev_csum),
    .done     (done),
    .fmt_err  (fmt_err),
    .csum_err (csum_err)
  );
endmodule

// File: rtl/tl_checker.sv
module tl_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic in_valid,
  input logic in_ready,
  input logic mem_we,
  input logic done,
  input logic csum_err,
  input logic fmt_err
);
  assert_status_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, csum_err, fmt_err}));

  assert_finished_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || csum_err || fmt_err) |-> !in_ready);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_csum_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csum_err && !start) |=> csum_err);

  assert_fmt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_err && !start) |=> fmt_err);

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !csum_err && !fmt_err && in_ready));

  assert_write_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (in_valid && in_ready));

  assert_write_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
endmodule

bind tape_loader tl_checker u_tl_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .mem_we   (mem_we),
  .done     (done),
  .csum_err (csum_err),
  .fmt_err  (fmt_err)
);

// File: tb/test_tape_loader.sv
module test_tape_loader;
  localparam int MW = 16;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_byte;
  logic        in_eos;
  logic        mem_we;
  logic [3:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        done, csum_err, fmt_err;

  int          nchk = 0;
  int          nerr = 0;
  int          nwr  = 0;
  logic [15:0] model [MW];
  logic        hit   [MW];

  tape_loader #(.MEM_WORDS(MW), .ZERO_LIMIT(11)) i_tape_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .in_eos(in_eos),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .csum_err(csum_err), .fmt_err(fmt_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < MW; i++) begin
      model[i] = 16'h0;
      hit[i]   = 1'b0;
    end
    nwr = 0;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    #1;
    if (mem_we) begin
      model[mem_addr] = mem_wdata;
      hit[mem_addr]   = 1'b1;
      nwr++;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
    in_eos   = 1'b0;
  endtask

  task automatic send_eos();
    @(negedge clk);
    in_valid = 1'b0;
    in_eos   = 1'b1;
    @(negedge clk);
    in_eos   = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    in_valid = 1'b0;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    clear_model();
  endtask

  task automatic put_word(input logic [15:0] w);
    put(w[15:8]);
    put(w[7:0]);
  endtask

  function automatic logic [15:0] word_of(input int org, input int cnt, input int k);
    return 16'(org * 16'h0101 + cnt * 16'h0031 + k * 16'h1357);
  endfunction

  task automatic send_record(input logic [15:0] org, input int cnt,
                             input logic [7:0] skip, input logic [15:0] bad);
    logic [15:0] sum;
    put(8'(cnt));
    put(skip);
    put_word(org);
    sum = org;
    for (int k = 0; k < cnt; k++) begin
      put_word(word_of(int'(org), cnt, k));
      sum = sum + word_of(int'(org), cnt, k);
    end
    put_word(sum ^ bad);
  endtask

  task automatic status_is(input string req, input logic d, input logic c, input logic f);
    chk(req, {29'd0, done, csum_err, fmt_err}, {29'd0, d, c, f});
  endtask

  task automatic check_writes(input string req, input int org, input int cnt);
    int exp_n = 0;
    for (int k = 0; k < cnt; k++) begin
      int a = (org + k) & 16'hFFFF;
      if (a < MW) begin
        exp_n++;
        chk(req, {15'd0, hit[a]}, 1);
        chk(req, int'(model[a]), int'(word_of(org, cnt, k)));
      end
    end
    chk("R6 write count", nwr, exp_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_byte = 8'h0; in_eos = 1'b0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    status_is("R1 reset status", 1'b0, 1'b0, 1'b0);
    chk("R1 reset ready", {31'd0, in_ready}, 1);
    chk("R1 reset no write", {31'd0, mem_we}, 0);

    // R2 long leader, R3 zero-valued discarded frame, R7 clean end of stream
    for (int i = 0; i < 40; i++) put(8'h00);
    settle();
    status_is("R2 leader zeros", 1'b0, 1'b0, 1'b0);
    chk("R2 leader ready", {31'd0, in_ready}, 1);
    chk("R2 leader writes", nwr, 0);
    send_record(16'h0004, 3, 8'h00, 16'h0);
    send_eos();
    status_is("R7 eos between records", 1'b1, 1'b0, 1'b0);
    check_writes("R3 R4 record A", 4, 3);

    // Sweep: origins across the memory top, several counts; R4 R5 R6 R8
    for (int org = 0; org < 20; org++) begin
      for (int cnt = 1; cnt <= 6; cnt++) begin
        pulse_start();
        for (int z = 0; z < (org % 4); z++) put(8'h00);
        send_record(16'(org), cnt, 8'(org * 7), 16'h0);
        for (int z = 0; z < 10; z++) put(8'h00);
        settle();
        status_is("R8 ten zeros keep running", 1'b0, 1'b0, 1'b0);
        put(8'h00);
        settle();
        status_is("R8 eleventh zero ends load", 1'b1, 1'b0, 1'b0);
        check_writes("R4 R6 sweep word", org, cnt);
      end
    end

    // R8 zero run shorter than the limit, then a second record
    pulse_start();
    send_record(16'h0000, 2, 8'hFF, 16'h0);
    for (int z = 0; z < 10; z++) put(8'h00);
    send_record(16'h0008, 2, 8'h11, 16'h0);
    send_eos();
    status_is("R8 second record after short gap", 1'b1, 1'b0, 1'b0);
    chk("R8 second record writes", nwr, 4);
    chk("R8 second record data", int'(model[9]), int'(word_of(8, 2, 1)));

    // R5 checksum mismatch, then R9 frames refused after the finish
    pulse_start();
    send_record(16'h0002, 2, 8'h33, 16'h0100);
    settle();
    status_is("R5 checksum mismatch", 1'b0, 1'b1, 1'b0);
    chk("R9 ready low after finish", {31'd0, in_ready}, 0);
    nwr = 0;
    for (int i = 0; i < 12; i++) put(8'(i + 1));
    settle();
    chk("R9 no writes after finish", nwr, 0);
    status_is("R9 status held", 1'b0, 1'b1, 1'b0);
    send_eos();
    status_is("R9 eos ignored after finish", 1'b0, 1'b1, 1'b0);

    // R1 start clears status
    pulse_start();
    status_is("R1 start clears", 1'b0, 1'b0, 1'b0);
    chk("R1 start ready", {31'd0, in_ready}, 1);

    // R7 end of stream inside records
    put(8'h02); put(8'h00); put(8'h00);
    send_eos();
    status_is("R7 eos inside origin", 1'b0, 1'b0, 1'b1);
    pulse_start();
    put(8'h01);
    send_eos();
    status_is("R7 eos after count", 1'b0, 1'b0, 1'b1);
    pulse_start();
    send_record(16'h0001, 1, 8'h44, 16'h0);
    put(8'h03); put(8'h00); put(8'h00); put(8'h05); put(8'h12);
    send_eos();
    status_is("R7 eos inside data", 1'b0, 1'b0, 1'b1);

    // R10 address wrap, R6 top address suppressed
    pulse_start();
    send_record(16'hFFFF, 2, 8'h00, 16'h0);
    send_eos();
    status_is("R10 wrap record checksum", 1'b1, 1'b0, 1'b0);
    chk("R10 wrap write count", nwr, 1);
    chk("R10 wrapped word at 0", int'(model[0]), int'(word_of(16'hFFFF, 2, 1)));

    settle();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule